// File: doc/BRIEF.md
# Line AIS Ones-Density Detector

This block monitors a recovered serial bit stream from a T1 or E1 line and decides whether the far end is sending an Alarm Indication Signal (an almost all-ones pattern). It counts the zeros that arrive within fixed, back-to-back windows of received bits. The window length and zero threshold depend on the line mode. At the close of each window the status is set if too few zeros arrived, and cleared otherwise.

A loss-of-signal input can force the alarm on, but only when a separate enable bit allows it. A detector enable freezes all state while the line clock is absent. The block drives a level status and a single-cycle change pulse, which a host status register can latch.

Top module: `ais_detector`

## Requirements
- R1: While rst_ni is low, ais_o and ais_chg_o are 0, and the bit and zero counters are cleared.
- R2: With mode_t1_i = 0 (E1), a window is 512 valid bits. The clock edge that takes the 512th bit sets ais_o to 1 if that window held fewer than 3 zeros, and to 0 if it held 3 or more.
- R3: With mode_t1_i = 1 (T1), a window is 8192 valid bits. The edge that takes the 8192nd bit sets ais_o to 1 if that window held fewer than 9 zeros, and to 0 if it held 9 or more.
- R4: Apart from the override in R6, ais_o changes only at a window end. Cycles with bit_vld_i = 0 are neither counted nor evaluated, whatever the value on bit_i.
- R5: While en_i = 0, all state holds. This covers counters, status and stored mode. ais_o does not change, and ais_chg_o is 0.
- R6: With en_i = 1, the clock edge on which los_i = 1 and rais_en_i = 1 sets ais_o to 1 and empties the current window. After los_i falls, evaluation starts from a fresh window.
- R7: With rais_en_i = 0, los_i has no effect. Windows are counted and evaluated as if los_i were 0.
- R8: With en_i = 1, a change of mode_t1_i discards the partial window. The new window starts with the first valid bit after the change.
- R9: ais_chg_o is 1 for exactly the one cycle in which ais_o has just taken a new value, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Line clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Detector enable; low freezes all state |
| bit_vld_i | input | 1 | Qualifies bit_i for this cycle |
| bit_i | input | 1 | Received data bit |
| mode_t1_i | input | 1 | Line mode: 0 = E1, 1 = T1 |
| los_i | input | 1 | Loss-of-signal indication |
| rais_en_i | input | 1 | Lets los_i force the alarm |
| ais_o | output | 1 | AIS status level |
| ais_chg_o | output | 1 | One-cycle pulse when ais_o changes |

## Verification
Several properties are checked on every cycle: the change pulse agrees with the status history, the status holds while disabled or while no valid bit arrives, and the loss-of-signal override takes effect. The exact window lengths can only be shown by the directed scenarios, which probe one bit before and at the window boundary. The same applies to the two thresholds, to a fresh window after a mode change or after the override, and to partial-window state being preserved across a disabled stretch.

// File: rtl/ais_pkg.sv
package ais_pkg;
  typedef enum logic {
    MODE_E1 = 1'b0,
    MODE_T1 = 1'b1
  } line_mode_e;
endpackage

// File: rtl/ais_bit_window.sv
module ais_bit_window #(
  parameter int unsigned CW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          restart_i,
  input  logic          vld_i,
  input  logic [CW-1:0] last_i,
  output logic          win_end_o
);
  logic [CW-1:0] cnt_q;

  assign win_end_o = en_i && vld_i && !restart_i && (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (en_i) begin
      if (restart_i || win_end_o) cnt_q <= '0;
      else if (vld_i)             cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ais_zero_count.sv
module ais_zero_count #(
  parameter int unsigned ZW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          restart_i,
  input  logic          vld_i,
  input  logic          bit_i,
  input  logic          win_end_i,
  input  logic [ZW-1:0] thr_i,
  output logic          below_o
);
  logic [ZW-1:0] zc_q, zc_inc;
  logic          is_zero;

  assign is_zero = vld_i && !bit_i;
  // saturate at the active threshold
  assign zc_inc  = (zc_q < thr_i && is_zero) ? zc_q + 1'b1 : zc_q;
  assign below_o = zc_inc < thr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    zc_q <= '0;
    else if (en_i) begin
      if (restart_i || win_end_i)   zc_q <= '0;
      else                          zc_q <= zc_inc;
    end
  end
endmodule

// File: rtl/ais_status.sv
module ais_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic force_i,
  input  logic win_end_i,
  input  logic below_i,
  output logic ais_o,
  output logic chg_o
);
  logic ais_q, ais_d, chg_q;

  always_comb begin
    ais_d = ais_q;
    if (force_i)        ais_d = 1'b1;
    else if (win_end_i) ais_d = below_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ais_q <= 1'b0;
      chg_q <= 1'b0;
    end else begin
      chg_q <= en_i && (ais_d != ais_q);
      if (en_i) ais_q <= ais_d;
    end
  end

  assign ais_o = ais_q;
  assign chg_o = chg_q;
endmodule

// File: rtl/ais_detector.sv
module ais_detector
  import ais_pkg::*;
#(
  parameter int unsigned E1_WIN = 512,
  parameter int unsigned E1_THR = 3,
  parameter int unsigned T1_WIN = 8192,
  parameter int unsigned T1_THR = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_vld_i,
  input  logic bit_i,
  input  logic mode_t1_i,
  input  logic los_i,
  input  logic rais_en_i,
  output logic ais_o,
  output logic ais_chg_o
);
  localparam int unsigned MAX_WIN = (E1_WIN > T1_WIN) ? E1_WIN : T1_WIN;
  localparam int unsigned MAX_THR = (E1_THR > T1_THR) ? E1_THR : T1_THR;
  localparam int unsigned CW      = $clog2(MAX_WIN);
  localparam int unsigned ZW      = $clog2(MAX_THR + 1);

  line_mode_e    mode_q, mode_in;
  logic          mode_chg, los_force, restart, win_end, below;
  logic [CW-1:0] last_sel;
  logic [ZW-1:0] thr_sel;

  assign mode_in   = line_mode_e'(mode_t1_i);
  assign mode_chg  = mode_in != mode_q;
  assign los_force = en_i && los_i && rais_en_i;
  assign restart   = mode_chg || (los_i && rais_en_i);
  assign last_sel  = (mode_in == MODE_T1) ? CW'(T1_WIN - 1) : CW'(E1_WIN - 1);
  assign thr_sel   = (mode_in == MODE_T1) ? ZW'(T1_THR) : ZW'(E1_THR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= MODE_E1;
    else if (en_i) mode_q <= mode_in;
  end

  ais_bit_window #(.CW(CW)) u_win (
    .clk_i, .rst_ni, .en_i,
    .restart_i (restart),
    .vld_i     (bit_vld_i),
    .last_i    (last_sel),
    .win_end_o (win_end)
  );

  ais_zero_count #(.ZW(ZW)) u_zc (
    .clk_i, .rst_ni, .en_i,
    .restart_i (restart),
    .vld_i     (bit_vld_i),
    .bit_i,
    .win_end_i (win_end),
    .thr_i     (thr_sel),
    .below_o   (below)
  );

  ais_status u_st (
    .clk_i, .rst_ni, .en_i,
    .force_i   (los_force),
    .win_end_i (win_end),
    .below_i   (below),
    .ais_o,
    .chg_o     (ais_chg_o)
  );
endmodule

// File: rtl/ais_detector_chk.sv
module ais_detector_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic bit_vld_i,
  input logic los_i,
  input logic rais_en_i,
  input logic ais_o,
  input logic ais_chg_o
);
  AST_CHG_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ais_chg_o == (ais_o != $past(ais_o))); // R9
  AST_NO_CHG_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !ais_chg_o); // R9
  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(ais_o)); // R5
  AST_HOLD_NO_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !bit_vld_i && !(los_i && rais_en_i) |=> $stable(ais_o)); // R4
  AST_LOS_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && los_i && rais_en_i |=> ais_o); // R6
endmodule

bind ais_detector ais_detector_chk u_chk (
  .clk_i, .rst_ni, .en_i, .bit_vld_i, .los_i, .rais_en_i, .ais_o, .ais_chg_o
);

// File: tb/tb_ais_detector.sv
`timescale 1ns/1ps
module tb_ais_detector;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic en_i = 1'b0, bit_vld_i = 1'b0, bit_i = 1'b1, mode_t1_i = 1'b0;
  logic los_i = 1'b0, rais_en_i = 1'b0;
  logic ais_o, ais_chg_o;
  int errors = 0, checks = 0;

  always #5 clk_i = ~clk_i;

  ais_detector dut (.*);

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  // n valid bits, the first nz of them zero
  task automatic send_bits(input int n, input int nz);
    for (int i = 0; i < n; i++) begin
      bit_vld_i = 1'b1; bit_i = (i >= nz); tick();
    end
    bit_vld_i = 1'b0; bit_i = 1'b1;
  endtask

  task automatic t_reset();
    check(ais_o, 1'b0, "R1 ais in reset");
    check(ais_chg_o, 1'b0, "R1 chg in reset");
    rst_ni = 1'b1; en_i = 1'b1; tick();
    check(ais_o, 1'b0, "R1 ais after reset");
  endtask

  task automatic t_e1_declare();
    send_bits(511, 0);
    check(ais_o, 1'b0, "R2/R4 no change before 512th bit");
    send_bits(1, 0);
    check(ais_o, 1'b1, "R2 declare on all ones");
    check(ais_chg_o, 1'b1, "R9 pulse on declare");
    tick();
    check(ais_chg_o, 1'b0, "R9 pulse lasts one cycle");
  endtask

  task automatic t_e1_thresholds();
    send_bits(512, 2);
    check(ais_o, 1'b1, "R2 two zeros keeps AIS");
    check(ais_chg_o, 1'b0, "R9 no pulse without change");
    send_bits(512, 3);
    check(ais_o, 1'b0, "R2 three zeros clears");
    check(ais_chg_o, 1'b1, "R9 pulse on clear");
  endtask

  task automatic t_invalid_ignored();
    for (int i = 0; i < 512; i++) begin
      bit_vld_i = 1'b0; bit_i = 1'b0; tick();
      bit_vld_i = 1'b1; bit_i = 1'b1; tick();
      if (i == 510) check(ais_o, 1'b0, "R4 invalid cycles not counted");
    end
    bit_vld_i = 1'b0; bit_i = 1'b1;
    check(ais_o, 1'b1, "R4 declare with gapped ones");
  endtask

  task automatic t_disable();
    send_bits(200, 3);
    en_i = 1'b0;
    for (int i = 0; i < 400; i++) begin
      bit_vld_i = 1'b1; bit_i = 1'b0; tick();
      if (ais_chg_o !== 1'b0) check(ais_chg_o, 1'b0, "R5 no pulse while disabled");
    end
    bit_vld_i = 1'b0;
    check(ais_o, 1'b1, "R5 status held while disabled");
    en_i = 1'b1;
    send_bits(311, 0);
    check(ais_o, 1'b1, "R5 partial window kept");
    send_bits(1, 0);
    check(ais_o, 1'b0, "R5 window completes after enable");
  endtask

  task automatic t_t1();
    mode_t1_i = 1'b1; tick();
    send_bits(8191, 8);
    check(ais_o, 1'b0, "R3 no change before 8192nd bit");
    send_bits(1, 0);
    check(ais_o, 1'b1, "R3 eight zeros declares");
    send_bits(8192, 9);
    check(ais_o, 1'b0, "R3 nine zeros clears");
  endtask

  task automatic t_mode_restart();
    send_bits(100, 0);
    mode_t1_i = 1'b0; tick();
    send_bits(511, 0);
    check(ais_o, 1'b0, "R8 fresh window after mode change");
    send_bits(1, 0);
    check(ais_o, 1'b1, "R8 E1 window ends after 512 new bits");
  endtask

  task automatic t_los_force();
    send_bits(512, 3);
    check(ais_o, 1'b0, "R6 precondition clear");
    rais_en_i = 1'b1; los_i = 1'b1; tick();
    check(ais_o, 1'b1, "R6 forced on next edge");
    check(ais_chg_o, 1'b1, "R9 pulse on forced set");
    send_bits(600, 600);
    check(ais_o, 1'b1, "R6 held while forced");
    los_i = 1'b0; tick();
    send_bits(511, 3);
    check(ais_o, 1'b1, "R6 fresh window after LOS");
    send_bits(1, 0);
    check(ais_o, 1'b0, "R6 evaluation resumes");
  endtask

  task automatic t_los_no_rais();
    rais_en_i = 1'b0; los_i = 1'b1; tick();
    check(ais_o, 1'b0, "R7 LOS ignored without enable");
    send_bits(511, 0);
    check(ais_o, 1'b0, "R7 still counting");
    send_bits(1, 0);
    check(ais_o, 1'b1, "R7 normal declare under LOS");
    los_i = 1'b0;
  endtask

  initial begin
    #1;
    t_reset();
    t_e1_declare();
    t_e1_thresholds();
    t_invalid_ignored();
    t_disable();
    t_t1();
    t_mode_restart();
    t_los_force();
    t_los_no_rais();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule